// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block traverses the linked chain of extended capability headers that lives in the upper part of a 4 KB configuration space. It reaches that space through one single-port, dword-addressed RAM port with a read latency of one cycle. A lookup command carries a capability identifier. The walker starts at the fixed root offset 0x100 and reads one header per hop, following each header's link field. It reports the offset of the first header that carries the identifier, or zero when no header does. It also reports the offset it visited just before the one it stopped at.

An insert command places a new header in the chain. It first checks the requested region. If the offset is not the root, it walks the chain with a key that can never match, which brings it to the last header. It then patches only the link field of that last header and writes the new header with an empty link. On success it sends one strobe carrying the region's base and size, so that the neighbouring mask storage can make the region read-only. Choosing where to place a capability, and filling in its body, belong to the caller.

Top module: `ecap_list_walker`

## Requirements
- R1: A header dword is decoded as identifier in bits 15:0, version in bits 19:16 and link offset in bits 31:20; a new header is written in that same packing.
- R2: A lookup always begins at byte offset 0x100. If the dword there is all zeros, the lookup ends with res_off = 0, res_prev = 0 and err = 0.
- R3: On a match, res_off holds the offset of the first header in chain order whose identifier equals cmd_id[15:0]. res_prev holds the offset visited before it, which is 0 when the match is at 0x100.
- R4: When a lookup reaches a header with link 0 and finds no match, res_off = 0 and res_prev holds the offset of that last header.
- R5: A lookup key with cmd_id[16] = 1 matches no header, so the lookup runs to the end of the chain exactly as in R4.
- R6: An offset the walker is about to read that is below 0x100 or above 0xFF8 makes err = 1 and ends the command. No read is issued at that offset.
- R7: A lookup reads at most HOP_LIMIT headers. If it would need to follow a link after the HOP_LIMIT-th header, it ends with err = 1. A self-referencing chain therefore costs exactly HOP_LIMIT reads.
- R8: An insert at offset 0x100 writes the new header there directly, with link 0, and reads no other header.
- R9: An insert at any other offset rewrites the last header's link field with the new offset and keeps that header's bits 19:0. It then writes {link 0, cmd_ver, cmd_id[15:0]} at the new offset and reports res_off = new offset and res_prev = last header offset.
- R10: An insert whose region fails any of these checks ends with err = 1 and no RAM write: offset at least 0x100, size non-zero, offset + size at most 0x1000, and offset a multiple of 4.
- R11: An insert at an offset other than 0x100 into an empty chain ends with err = 1 and no RAM write.
- R12: A successful insert raises mask_clr for exactly one cycle, in the same cycle as done, with mask_base and mask_size equal to the region. Failed commands and lookups never raise it.
- R13: A command is taken only while busy = 0. done is high for one cycle per command. res_off, res_prev and err hold their values until the next command is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_append | input | 1 | 1 = insert, 0 = lookup |
| cmd_id | input | 17 | Identifier; bit 16 set gives a key that never matches |
| cmd_ver | input | 4 | Version for an inserted header |
| cmd_off | input | 12 | Byte offset of the region to insert |
| cmd_size | input | 13 | Byte size of the region to insert |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command ended in error (held) |
| res_off | output | 12 | Matched or inserted offset, 0 when none |
| res_prev | output | 12 | Previously visited offset, or last header offset |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 10 | RAM dword address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, valid the cycle after a read |
| mask_clr | output | 1 | Strobe to clear the write and write-one-to-clear masks of a region |
| mask_base | output | 12 | Base offset of that region |
| mask_size | output | 13 | Size of that region |

## Verification
Internal faults in this block show up on the RAM port and on the result registers. A wrong link decode or a wrong hop state makes the walker read the wrong dword addresses. That shows as a wrong number of reads and a wrong res_off/res_prev pair when done rises, a few cycles after the command. A bad patch of the last header is seen at once in the RAM contents: its identifier bits change, or its link field does not point to the new region. A missing range or region check shows as a read outside the legal offsets or as a write count that is not zero on a rejected insert. A broken hop guard shows as a self-referencing chain that never completes, or that does not cost exactly HOP_LIMIT reads.

// File: rtl/ecap_walk_pkg.sv
package ecap_walk_pkg;
   localparam int ID_W    = 16;
   localparam int VER_W   = 4;
   localparam int NXT_W   = 12;
   localparam int HDR_W   = ID_W + VER_W + NXT_W;
   localparam int VER_LSB = ID_W;
   localparam int NXT_LSB = ID_W + VER_W;

   typedef enum logic [2:0] {
      S_IDLE, S_READ, S_CHECK, S_WTAIL, S_WNEW, S_DONE, S_ERR
   } walk_st_t;

   function automatic logic [HDR_W-1:0] hdr_pack(input logic [ID_W-1:0] id,
                                                 input logic [VER_W-1:0] ver,
                                                 input logic [NXT_W-1:0] nxt);
      return {nxt, ver, id};
   endfunction
endpackage

// File: rtl/ecap_hdr_codec.sv
module ecap_hdr_codec
   import ecap_walk_pkg::*;
(
   input  logic [HDR_W-1:0] rd_hdr,
   output logic [ID_W-1:0]  rd_id,
   output logic [NXT_W-1:0] rd_nxt,
   output logic             rd_zero,
   input  logic [HDR_W-1:0] patch_src,
   input  logic [NXT_W-1:0] patch_nxt,
   output logic [HDR_W-1:0] patched,
   input  logic [ID_W-1:0]  new_id,
   input  logic [VER_W-1:0] new_ver,
   output logic [HDR_W-1:0] new_hdr
);
   // field split of a header read from RAM
   assign rd_id   = rd_hdr[ID_W-1:0];
   assign rd_nxt  = rd_hdr[HDR_W-1:NXT_LSB];
   assign rd_zero = (rd_hdr == '0);

   // only the link field of the last header is replaced
   assign patched = {patch_nxt, patch_src[NXT_LSB-1:0]};
   assign new_hdr = hdr_pack(new_id, new_ver, '0);
endmodule

// File: rtl/ecap_bounds.sv
module ecap_bounds #(
   parameter int OFFW         = 12,
   parameter int BASE         = 256,
   parameter bit STRICT_ALIGN = 1'b1
) (
   input  logic [OFFW-1:0] visit_off,
   output logic            visit_ok,
   input  logic [OFFW-1:0] reg_off,
   input  logic [OFFW:0]   reg_size,
   output logic            region_ok
);
   localparam logic [OFFW-1:0] BASE_V  = OFFW'(BASE);
   localparam logic [OFFW-1:0] LAST_V  = OFFW'((1 << OFFW) - 8);
   localparam logic [OFFW+1:0] SPACE_V = (OFFW+2)'(1 << OFFW);

   logic [OFFW+1:0] reg_end;
   logic            align_ok;

   assign visit_ok = (visit_off >= BASE_V) && (visit_off <= LAST_V);
   assign reg_end  = {2'b00, reg_off} + {1'b0, reg_size};

   generate
      if (STRICT_ALIGN) begin : g_align
         assign align_ok = (reg_off[1:0] == 2'b00);
      end else begin : g_noalign
         assign align_ok = 1'b1;
      end
   endgenerate

   assign region_ok = (reg_off >= BASE_V) && (reg_size != '0) &&
                      (reg_end <= SPACE_V) && align_ok;
endmodule

// File: rtl/ecap_hop_guard.sv
module ecap_hop_guard #(
   parameter int LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic last
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);
   localparam logic [CW-1:0] MAX_V  = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (clr)                     cnt <= '0;
      else if (step && (cnt != MAX_V))  cnt <= cnt + 1'b1;
   end

   // cnt = headers already examined in this walk
   assign last = (cnt == LAST_V);

   // the walk must stop before examining more than LIMIT headers
   assert_hop_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (cnt < MAX_V));
endmodule

// File: rtl/ecap_list_walker.sv
module ecap_list_walker
   import ecap_walk_pkg::*;
#(
   parameter int BASE         = 256,
   parameter int HOP_LIMIT    = 1024,
   parameter bit STRICT_ALIGN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_append,
   input  logic [ID_W:0]     cmd_id,
   input  logic [VER_W-1:0]  cmd_ver,
   input  logic [NXT_W-1:0]  cmd_off,
   input  logic [NXT_W:0]    cmd_size,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [NXT_W-1:0]  res_off,
   output logic [NXT_W-1:0]  res_prev,
   output logic              mem_en,
   output logic              mem_we,
   output logic [NXT_W-3:0]  mem_addr,
   output logic [HDR_W-1:0]  mem_wdata,
   input  logic [HDR_W-1:0]  mem_rdata,
   output logic              mask_clr,
   output logic [NXT_W-1:0]  mask_base,
   output logic [NXT_W:0]    mask_size
);
   localparam int OFFW = NXT_W;
   localparam int AW   = OFFW - 2;
   localparam logic [OFFW-1:0] BASE_V = OFFW'(BASE);

   generate
      if (HOP_LIMIT < 1) begin : g_bad_limit
         $error("HOP_LIMIT must be at least 1");
      end
      if ((BASE % 4) != 0 || BASE >= (1 << OFFW)) begin : g_bad_base
         $error("BASE must be dword aligned and inside the space");
      end
   endgenerate

   walk_st_t         st;
   logic             app_q;
   logic [ID_W:0]    id_q;
   logic [VER_W-1:0] ver_q;
   logic [OFFW-1:0]  aoff_q;
   logic [OFFW:0]    asize_q;
   logic [OFFW-1:0]  cur_q, prev_q;
   logic [HDR_W-1:0] tail_q;
   logic [OFFW-1:0]  res_off_q, res_prev_q;
   logic             err_q, mclr_q;

   logic [ID_W-1:0]  rd_id;
   logic [OFFW-1:0]  rd_nxt;
   logic             rd_zero;
   logic [HDR_W-1:0] patched, new_hdr;
   logic             visit_ok, region_ok, hop_last;
   logic             take, key_hit;

   ecap_hdr_codec u_codec (
      .rd_hdr   (mem_rdata),
      .rd_id    (rd_id),
      .rd_nxt   (rd_nxt),
      .rd_zero  (rd_zero),
      .patch_src(tail_q),
      .patch_nxt(aoff_q),
      .patched  (patched),
      .new_id   (id_q[ID_W-1:0]),
      .new_ver  (ver_q),
      .new_hdr  (new_hdr)
   );

   ecap_bounds #(.OFFW(OFFW), .BASE(BASE), .STRICT_ALIGN(STRICT_ALIGN)) u_bounds (
      .visit_off(cur_q),
      .visit_ok (visit_ok),
      .reg_off  (cmd_off),
      .reg_size (cmd_size),
      .region_ok(region_ok)
   );

   ecap_hop_guard #(.LIMIT(HOP_LIMIT)) u_hops (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (take),
      .step (st == S_CHECK),
      .last (hop_last)
   );

   assign take    = cmd_valid && (st == S_IDLE);
   // an insert searches with an unmatchable key to reach the last header
   assign key_hit = !app_q && !id_q[ID_W] && (rd_id == id_q[ID_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         app_q      <= 1'b0;
         id_q       <= '0;
         ver_q      <= '0;
         aoff_q     <= '0;
         asize_q    <= '0;
         cur_q      <= '0;
         prev_q     <= '0;
         tail_q     <= '0;
         res_off_q  <= '0;
         res_prev_q <= '0;
         err_q      <= 1'b0;
         mclr_q     <= 1'b0;
      end else begin
         mclr_q <= 1'b0;
         unique case (st)
            S_IDLE: if (cmd_valid) begin
               app_q   <= cmd_append;
               id_q    <= cmd_id;
               ver_q   <= cmd_ver;
               aoff_q  <= cmd_off;
               asize_q <= cmd_size;
               cur_q   <= BASE_V;
               prev_q  <= '0;
               err_q   <= 1'b0;
               if (!cmd_append)          st <= S_READ;
               else if (!region_ok)      st <= S_ERR;
               else if (cmd_off == BASE_V) st <= S_WNEW;
               else                      st <= S_READ;
            end
            S_READ: st <= visit_ok ? S_CHECK : S_ERR;
            S_CHECK: begin
               if (rd_zero && (cur_q == BASE_V)) begin
                  res_off_q  <= '0;
                  res_prev_q <= '0;
                  st         <= app_q ? S_ERR : S_DONE;
               end else if (key_hit) begin
                  res_off_q  <= cur_q;
                  res_prev_q <= prev_q;
                  st         <= S_DONE;
               end else if (rd_nxt == '0) begin
                  prev_q <= cur_q;
                  tail_q <= mem_rdata;
                  if (app_q) begin
                     st <= S_WTAIL;
                  end else begin
                     res_off_q  <= '0;
                     res_prev_q <= cur_q;
                     st         <= S_DONE;
                  end
               end else if (hop_last) begin
                  st <= S_ERR;
               end else begin
                  prev_q <= cur_q;
                  cur_q  <= rd_nxt;
                  st     <= S_READ;
               end
            end
            S_WTAIL: st <= S_WNEW;
            S_WNEW: begin
               res_off_q  <= aoff_q;
               res_prev_q <= prev_q;
               mclr_q     <= 1'b1;
               st         <= S_DONE;
            end
            S_ERR: begin
               err_q     <= 1'b1;
               res_off_q <= '0;
               st        <= S_DONE;
            end
            S_DONE: st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_q[OFFW-1:2];
      mem_wdata = '0;
      unique case (st)
         S_READ:  mem_en = visit_ok;
         S_WTAIL: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = prev_q[OFFW-1:2];
            mem_wdata = patched;
         end
         S_WNEW: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = aoff_q[OFFW-1:2];
            mem_wdata = new_hdr;
         end
         default: ;
      endcase
   end

   assign busy      = (st != S_IDLE);
   assign done      = (st == S_DONE);
   assign err       = err_q;
   assign res_off   = res_off_q;
   assign res_prev  = res_prev_q;
   assign mask_clr  = mclr_q;
   assign mask_base = aoff_q;
   assign mask_size = asize_q;

   // reads never leave the legal header window
   assert_read_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we) |-> ((mem_addr >= AW'(BASE >> 2)) &&
                               (mem_addr <= AW'(((1 << OFFW) - 8) >> 2))));
   // an error becomes visible together with completion
   assert_err_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);
   // mask strobe only on a successful insert completion
   assert_mask_ok_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mask_clr |-> (done && !err));
   assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_accept_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy) |=> busy);
   assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cmd_valid) |=> ($stable(res_off) && $stable(res_prev) && $stable(err)));
   // the new header always carries an empty link
   assert_new_link_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_wdata[HDR_W-1:NXT_LSB] == '0));
endmodule

// File: tb/ecap_list_walker_tb.sv
`timescale 1ns/1ps
module ecap_list_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_append = 1'b0;
   logic [16:0] cmd_id = '0;
   logic [3:0]  cmd_ver = '0;
   logic [11:0] cmd_off = '0;
   logic [12:0] cmd_size = '0;
   logic        busy, done, err, mem_en, mem_we, mask_clr;
   logic [11:0] res_off, res_prev, mask_base;
   logic [12:0] mask_size;
   logic [9:0]  mem_addr;
   logic [31:0] mem_wdata, mem_rdata;

   always #4 clk = ~clk; // 125 MHz

   ecap_list_walker dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_append(cmd_append),
      .cmd_id(cmd_id), .cmd_ver(cmd_ver), .cmd_off(cmd_off), .cmd_size(cmd_size),
      .busy(busy), .done(done), .err(err), .res_off(res_off), .res_prev(res_prev),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mask_clr(mask_clr), .mask_base(mask_base),
      .mask_size(mask_size));

   // RAM model with a bench-side write port and access counters
   logic [31:0] ram [1024];
   logic        tb_we = 1'b0, tb_clr = 1'b0;
   logic [9:0]  tb_addr = '0;
   logic [31:0] tb_wdata = '0;
   int          n_rd = 0, n_wr = 0, n_mask = 0;

   always_ff @(posedge clk) begin
      if (tb_clr) begin
         for (int i = 0; i < 1024; i++) ram[i] <= '0;
      end else if (tb_we) begin
         ram[tb_addr] <= tb_wdata;
      end else if (mem_en && mem_we) begin
         ram[mem_addr] <= mem_wdata;
      end
      if (mem_en && !mem_we) mem_rdata <= ram[mem_addr];
      if (mem_en && !mem_we) n_rd <= n_rd + 1;
      if (mem_en && mem_we)  n_wr <= n_wr + 1;
      if (mask_clr)          n_mask <= n_mask + 1;
   end

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] hdr(input logic [15:0] id, input logic [3:0] v, input logic [11:0] nx);
      return {nx, v, id}; // R1 packing
   endfunction

   task automatic poke(input logic [11:0] off, input logic [31:0] d);
      @(negedge clk);
      tb_we = 1'b1; tb_addr = off[11:2]; tb_wdata = d;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic wipe();
      @(negedge clk); tb_clr = 1'b1;
      @(negedge clk); tb_clr = 1'b0;
   endtask

   int rd0, wr0, mk0;
   logic [11:0] mb_seen; logic [12:0] ms_seen; logic mk_seen;

   task automatic run(input logic app, input logic [16:0] id, input logic [3:0] v,
                      input logic [11:0] off, input logic [12:0] sz);
      int n;
      @(negedge clk);
      rd0 = n_rd; wr0 = n_wr; mk0 = n_mask;
      cmd_valid = 1'b1; cmd_append = app; cmd_id = id; cmd_ver = v; cmd_off = off; cmd_size = sz;
      @(negedge clk);
      cmd_valid = 1'b0;
      n = 0;
      while (!done && n < 5000) begin @(negedge clk); n++; end
      chk(done, "R13 done timeout", {31'd0, done}, 32'd1);
      mk_seen = mask_clr; mb_seen = mask_base; ms_seen = mask_size;
      @(negedge clk);
      chk(!done, "R13 done one cycle", {31'd0, done}, 32'd0);
   endtask

   task automatic std_list();
      wipe();
      poke(12'h100, hdr(16'h0001, 4'h1, 12'h140));
      poke(12'h140, hdr(16'h000E, 4'h1, 12'h200));
      poke(12'h200, hdr(16'h0003, 4'h1, 12'h000));
   endtask

   // {key, exp_off, exp_prev, exp_reads}
   localparam logic [16+12+12+8:0] VEC [6] = '{
      {17'h00001, 12'h100, 12'h000, 8'd1},   // R3 first
      {17'h0000E, 12'h140, 12'h100, 8'd2},   // R3 middle
      {17'h00003, 12'h200, 12'h140, 8'd3},   // R3 last
      {17'h00005, 12'h000, 12'h200, 8'd3},   // R4 miss
      {17'h10001, 12'h000, 12'h200, 8'd3},   // R5 wide key
      {17'h1000E, 12'h000, 12'h200, 8'd3}    // R5 wide key
   };

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state R13
      chk(!busy && !done && !err, "R13 reset flags", {29'd0, busy, done, err}, 32'd0);
      chk(res_off == 0 && res_prev == 0 && !mem_en && !mask_clr, "R13 reset outputs",
          {res_off, res_prev}, 32'd0);
      rst_n = 1'b1;
      std_list();

      foreach (VEC[i]) begin
         run(1'b0, VEC[i][48:32], 4'h0, 12'h0, 13'h0);
         chk(res_off == VEC[i][31:20] && !err, "R3/R4/R5 res_off", {20'd0, res_off}, {20'd0, VEC[i][31:20]});
         chk(res_prev == VEC[i][19:8], "R3/R4/R5 res_prev", {20'd0, res_prev}, {20'd0, VEC[i][19:8]});
         chk(n_rd - rd0 == int'(VEC[i][7:0]), "R1 reads per lookup", n_rd - rd0, {24'd0, VEC[i][7:0]});
      end

      // R2 empty chain
      wipe();
      run(1'b0, 17'h00001, 4'h0, 12'h0, 13'h0);
      chk(res_off == 0 && res_prev == 0 && !err, "R2 empty lookup", {res_off, res_prev}, 32'd0);

      // R11 insert into empty chain off the root
      run(1'b1, 17'h00020, 4'h1, 12'h200, 13'h10);
      chk(err && n_wr == wr0, "R11 empty insert rejected", {31'd0, err}, 32'd1);

      // R8 insert at root
      run(1'b1, 17'h00021, 4'h3, 12'h100, 13'h40);
      chk(!err && n_wr - wr0 == 1 && n_rd == rd0, "R8 root insert access", n_wr - wr0, 32'd1);
      chk(ram[12'h100 >> 2] == hdr(16'h0021, 4'h3, 12'h000), "R8 root header", ram[64], hdr(16'h0021, 4'h3, 12'h0));
      chk(mk_seen && mb_seen == 12'h100 && ms_seen == 13'h40, "R12 mask strobe root", {19'd0, ms_seen}, 32'h40);

      // R9 insert at tail of standard chain
      std_list();
      run(1'b1, 17'h00010, 4'h2, 12'h300, 13'h10);
      chk(!err && res_off == 12'h300 && res_prev == 12'h200, "R9 insert result", {res_off, res_prev}, {12'h300, 12'h200});
      chk(ram[12'h200 >> 2] == hdr(16'h0003, 4'h1, 12'h300), "R9 tail patched", ram[128], hdr(16'h0003, 4'h1, 12'h300));
      chk(ram[12'h300 >> 2] == hdr(16'h0010, 4'h2, 12'h000), "R9 new header", ram[192], hdr(16'h0010, 4'h2, 12'h0));
      chk(n_wr - wr0 == 2 && n_mask - mk0 == 1, "R12 insert strobe count", n_mask - mk0, 32'd1);
      run(1'b0, 17'h00010, 4'h0, 12'h0, 13'h0);
      chk(res_off == 12'h300 && res_prev == 12'h200, "R9 lookup after insert", {res_off, res_prev}, {12'h300, 12'h200});

      // R10 bad regions
      run(1'b1, 17'h00011, 4'h1, 12'h0FC, 13'h10);
      chk(err && n_wr == wr0 && n_mask == mk0, "R10 low offset", {31'd0, err}, 32'd1);
      run(1'b1, 17'h00011, 4'h1, 12'h400, 13'h0);
      chk(err && n_wr == wr0 && n_mask == mk0, "R10 zero size", {31'd0, err}, 32'd1);
      run(1'b1, 17'h00011, 4'h1, 12'hFF0, 13'h20);
      chk(err && n_wr == wr0 && n_mask == mk0, "R10 past end", {31'd0, err}, 32'd1);
      run(1'b1, 17'h00011, 4'h1, 12'h402, 13'h4);
      chk(err && n_wr == wr0 && n_mask == mk0, "R10 misaligned", {31'd0, err}, 32'd1);
      run(1'b1, 17'h00011, 4'h1, 12'hFF8, 13'h8);
      chk(!err && n_wr - wr0 == 2, "R10 exact fit accepted", n_wr - wr0, 32'd2);

      // R6 link beyond window and below base
      std_list();
      poke(12'h200, hdr(16'h0003, 4'h1, 12'hFFC));
      run(1'b0, 17'h00099, 4'h0, 12'h0, 13'h0);
      chk(err && n_rd - rd0 == 3, "R6 high link", n_rd - rd0, 32'd3);
      poke(12'h140, hdr(16'h000E, 4'h1, 12'h040));
      run(1'b0, 17'h00099, 4'h0, 12'h0, 13'h0);
      chk(err && n_rd - rd0 == 2 && res_off == 0, "R6 low link", n_rd - rd0, 32'd2);
      // R13 err cleared by next good command
      run(1'b0, 17'h00001, 4'h0, 12'h0, 13'h0);
      chk(!err && res_off == 12'h100, "R13 err cleared", {31'd0, err}, 32'd0);

      // R7 self-referencing chain
      wipe();
      poke(12'h100, hdr(16'h0001, 4'h1, 12'h100));
      run(1'b0, 17'h00002, 4'h0, 12'h0, 13'h0);
      chk(err && n_rd - rd0 == 1024, "R7 hop limit", n_rd - rd0, 32'd1024);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule